// File: doc/BRIEF.md
# VFD Grid-Multiplexed Display Scanner

This block refreshes a vacuum fluorescent display one digit at a time. It holds the segment pattern of every digit in a small internal RAM and switches on one grid at a time. While a grid is on, the block drives that digit's segment pattern onto the segment pins. A host loads the RAM through a byte-wide write port. Each write takes effect from the next clock, so the new pattern appears the next time its digit is scanned.

A 3-bit mode sets how many digits and segments are used, from 4 digits of 16 segments up to 11 digits of 11 segments. Five shared pins act as segments or as grids, depending on the mode. A 3-bit dim value sets how long each grid stays on within its time slot, in eight steps. A short blanking gap at the start of every slot keeps ghost images from the previous digit off the glass. At the clock edge that ends each full scan, the block latches a 4-bit switch port, so the host reads a value that is stable for the whole frame.

Top module: `vfd_scan`

## Requirements
- R1: Digit d (0-based) occupies byte addresses 2d and 2d+1. The even byte holds segments 1 to 8 and the odd byte holds segments 9 to 16, with bit 0 as the lowest segment of each byte. Segments 1 to 11 appear on `seg_o[0]` to `seg_o[10]`. Writes to addresses 22 to 31 change nothing.
- R2: Mode m (0 to 7) gives G = 4 + m grids. Shared pin k (0 to 4) is grid 11-k when G >= 11-k. Otherwise it is segment 12+k and carries bit 11+k of the digit word.
- R3: Each digit slot lasts SLOT_CYCLES clocks. The digit index steps 0, 1, … G-1 and then wraps to 0. `frame_end_o` is high only during the last clock of the last slot of a frame.
- R4: At most one grid output (dedicated or shared) is high at any time, and only the grid numbered by the current digit index can be high.
- R5: Within a slot, a grid is on for slot cycles c with DEAD_CYCLES <= c < (dim+1)·SLOT_CYCLES/8.
- R6: All segment outputs are low for the first DEAD_CYCLES clocks of every slot and follow the RAM for the rest of the slot.
- R7: A shared pin that acts as a grid ignores its RAM bit. It goes high only as a grid, during its own digit's on-window.
- R8: While `disp_en_i` is low, every segment, grid and shared output is low, and scanning keeps running.
- R9: `sw_latched_o` takes the value of `sw_i` on the clock edge that ends a frame and holds it at all other times.
- R10: A byte written on one clock edge is visible on the outputs from the next cycle on, including in the slot that is currently being scanned.
- R11: After reset the scan starts at digit 0, slot cycle 0. The RAM and the switch latch are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_en_i | input | 1 | Display enable; low blanks all outputs |
| mode_i | input | 3 | Digit/segment mode, G = 4 + mode_i |
| dim_i | input | 3 | Grid on-time step |
| wr_en_i | input | 1 | RAM byte write strobe |
| wr_addr_i | input | 5 | RAM byte address |
| wr_data_i | input | 8 | RAM byte data |
| sw_i | input | 4 | Switch inputs |
| seg_o | output | 11 | Dedicated segments 1–11 |
| grid_o | output | 6 | Dedicated grids 1–6 |
| shared_o | output | 5 | Shared pins: segment 12+k or grid 11-k |
| frame_end_o | output | 1 | One-cycle end-of-frame pulse |
| sw_latched_o | output | 4 | Switch value latched at the last frame end |

## Verification
The bench builds the block with SLOT_CYCLES = 32 and DEAD_CYCLES = 2. With these values a full 11-digit frame is only 352 clocks, so several modes and frames fit in each scenario. The dim step then spans 4 clocks, so dim 0 gives a 2-clock grid pulse, just after the blanking gap. The short slot also lets the bench check every cycle of whole frames. This covers the grid/segment role of each shared pin in modes 0, 3 and 7, a write that lands in the middle of the slot being shown, and switch changes that occur mid-frame.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  localparam int NSEG_DED  = 11;
  localparam int NGRID_DED = 6;
  localparam int NSHARED   = 5;
  localparam int NDIG_MAX  = NGRID_DED + NSHARED;
  localparam int WORD_W    = NSEG_DED + NSHARED;
  localparam int BYTE_W    = WORD_W / 2;
  localparam int DIG_W     = $clog2(NDIG_MAX);
  localparam int ADDR_W    = DIG_W + 1;
  localparam int SW_W      = 4;
  localparam int MODE_W    = 3;
  localparam int MIN_GRIDS = 4;

  // grids in use for a mode value
  function automatic logic [DIG_W-1:0] grid_count(input logic [MODE_W-1:0] mode);
    return DIG_W'(mode) + DIG_W'(MIN_GRIDS);
  endfunction

  // shared pin k doubles as grid (NDIG_MAX - k) in 1-based numbering
  function automatic logic pin_is_grid(input logic [MODE_W-1:0] mode, input int k);
    return (int'(grid_count(mode)) + k) >= NDIG_MAX;
  endfunction

  // end (exclusive) of the grid on-window, in slot cycles
  function automatic int grid_on_end(input logic [2:0] dim, input int step);
    return (int'(dim) + 1) * step;
  endfunction
endpackage

// File: rtl/vfd_ram.sv
module vfd_ram
  import vfd_pkg::*;
#(
  parameter int NWORDS = NDIG_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [DIG_W-1:0]  rd_digit_i,
  output logic [WORD_W-1:0] rd_word_o
);
  localparam int NBYTES = 2 * NWORDS;

  logic [BYTE_W-1:0] bytes_q [NBYTES];
  logic              wr_ok;
  logic [ADDR_W-1:0] lo_idx, hi_idx;

  assign wr_ok  = wr_en_i && (wr_addr_i < ADDR_W'(NBYTES));
  assign lo_idx = {rd_digit_i, 1'b0};
  assign hi_idx = {rd_digit_i, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) bytes_q[i] <= '0;
    end else if (wr_ok) begin
      bytes_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_word_o = '0;
    if (rd_digit_i < DIG_W'(NWORDS)) rd_word_o = {bytes_q[hi_idx], bytes_q[lo_idx]};
  end

  // R10: an accepted byte is stored by the next cycle
  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (bytes_q[$past(wr_addr_i)] == $past(wr_data_i)));
endmodule

// File: rtl/vfd_timer.sv
module vfd_timer
  import vfd_pkg::*;
#(
  parameter int SLOT_CYCLES = 64,
  localparam int SLOT_W = $clog2(SLOT_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SW_W-1:0]   sw_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [DIG_W-1:0]  digit_o,
  output logic              frame_end_o,
  output logic [SW_W-1:0]   sw_latched_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [DIG_W-1:0]  digit_q;
  logic [SW_W-1:0]   sw_q;
  logic              slot_last, digit_last;

  assign slot_last   = (slot_q == SLOT_W'(SLOT_CYCLES - 1));
  assign digit_last  = (digit_q >= grid_count(mode_i) - DIG_W'(1));
  assign frame_end_o = slot_last && digit_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      digit_q <= '0;
      sw_q    <= '0;
    end else if (slot_last) begin
      slot_q <= '0;
      if (digit_last) begin
        digit_q <= '0;
        sw_q    <= sw_i;
      end else begin
        digit_q <= digit_q + DIG_W'(1);
      end
    end else begin
      slot_q <= slot_q + SLOT_W'(1);
    end
  end

  assign slot_o       = slot_q;
  assign digit_o      = digit_q;
  assign sw_latched_o = sw_q;

  // R3: a frame end restarts the scan at digit 0, cycle 0
  assert_frame_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> (digit_q == '0) && (slot_q == '0));
  // R3: a slot end inside a frame moves to the next digit
  assert_digit_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_last && !frame_end_o) |=> (digit_q == $past(digit_q) + DIG_W'(1)));
  // R9: switches are captured at the frame end
  assert_sw_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> (sw_q == $past(sw_i)));
  // R9: and held otherwise
  assert_sw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_o |=> $stable(sw_q));
endmodule

// File: rtl/vfd_drive.sv
module vfd_drive
  import vfd_pkg::*;
#(
  parameter int SLOT_CYCLES = 64,
  parameter int DEAD_CYCLES = 2,
  localparam int SLOT_W = $clog2(SLOT_CYCLES),
  localparam int STEP   = SLOT_CYCLES / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic [MODE_W-1:0]    mode_i,
  input  logic [2:0]           dim_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [DIG_W-1:0]     digit_i,
  input  logic [WORD_W-1:0]    word_i,
  output logic [NSEG_DED-1:0]  seg_o,
  output logic [NGRID_DED-1:0] grid_o,
  output logic [NSHARED-1:0]   shared_o
);
  logic              seg_window, grid_window;
  logic [SLOT_W:0]   grid_end;
  logic [NSHARED-1:0] pin_grid;

  assign grid_end    = (SLOT_W + 1)'(grid_on_end(dim_i, STEP));
  assign seg_window  = en_i && (slot_i >= SLOT_W'(DEAD_CYCLES));
  assign grid_window = seg_window && ({1'b0, slot_i} < grid_end);
  assign seg_o       = seg_window ? word_i[NSEG_DED-1:0] : '0;

  for (genvar j = 0; j < NGRID_DED; j++) begin : g_grid
    assign grid_o[j] = grid_window && (digit_i == DIG_W'(j));
  end

  for (genvar k = 0; k < NSHARED; k++) begin : g_shared
    localparam int GIDX = NDIG_MAX - 1 - k;
    assign pin_grid[k] = pin_is_grid(mode_i, k);
    assign shared_o[k] = pin_grid[k] ? (grid_window && (digit_i == DIG_W'(GIDX)))
                                     : (seg_window && word_i[NSEG_DED + k]);
    // R7: a shared grid pin never shows RAM content
    assert_grid_pin_ignores_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_grid[k] && (digit_i != DIG_W'(GIDX))) |-> !shared_o[k]);
  end

  // R4: never more than one grid lit
  assert_single_grid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shared_o & pin_grid, grid_o}));
  // R5: lit grid lies inside the dim window
  assert_dim_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grid_o) || (|(shared_o & pin_grid))) |->
      ((int'(slot_i) >= DEAD_CYCLES) && (int'(slot_i) < (int'(dim_i) + 1) * STEP)));
  // R6: blanking gap at the slot start
  assert_dead_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slot_i) < DEAD_CYCLES) |-> ((seg_o == '0) && ((shared_o & ~pin_grid) == '0)));
  // R8: disabled display is dark
  assert_disable_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> ((seg_o == '0) && (grid_o == '0) && (shared_o == '0)));
endmodule

// File: rtl/vfd_scan.sv
module vfd_scan
  import vfd_pkg::*;
#(
  parameter int SLOT_CYCLES = 64,
  parameter int DEAD_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disp_en_i,
  input  logic [MODE_W-1:0]    mode_i,
  input  logic [2:0]           dim_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [BYTE_W-1:0]    wr_data_i,
  input  logic [SW_W-1:0]      sw_i,
  output logic [NSEG_DED-1:0]  seg_o,
  output logic [NGRID_DED-1:0] grid_o,
  output logic [NSHARED-1:0]   shared_o,
  output logic                 frame_end_o,
  output logic [SW_W-1:0]      sw_latched_o
);
  localparam int SLOT_W = $clog2(SLOT_CYCLES);

  logic [SLOT_W-1:0] slot;
  logic [DIG_W-1:0]  digit;
  logic [WORD_W-1:0] word;

  vfd_ram #(.NWORDS(NDIG_MAX)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_digit_i(digit), .rd_word_o(word)
  );

  vfd_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sw_i(sw_i), .slot_o(slot),
    .digit_o(digit), .frame_end_o(frame_end_o), .sw_latched_o(sw_latched_o)
  );

  vfd_drive #(.SLOT_CYCLES(SLOT_CYCLES), .DEAD_CYCLES(DEAD_CYCLES)) u_drive (
    .clk(clk), .rst_n(rst_n), .en_i(disp_en_i), .mode_i(mode_i), .dim_i(dim_i),
    .slot_i(slot), .digit_i(digit), .word_i(word), .seg_o(seg_o), .grid_o(grid_o),
    .shared_o(shared_o)
  );
endmodule

// File: tb/vfd_scan_test.sv
`timescale 1ns/1ps
module vfd_scan_test;
  localparam int SLOT = 32;
  localparam int DEAD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_en = 1'b0;
  logic [2:0]  mode = 3'd7;
  logic [2:0]  dim = 3'd7;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  sw = '0;
  logic [10:0] seg;
  logic [5:0]  grid;
  logic [4:0]  shr;
  logic        fend;
  logic [3:0]  swl;

  int checks = 0;
  int errors = 0;

  vfd_scan #(.SLOT_CYCLES(SLOT), .DEAD_CYCLES(DEAD)) uut (
    .clk(clk), .rst_n(rst_n), .disp_en_i(disp_en), .mode_i(mode), .dim_i(dim),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .sw_i(sw),
    .seg_o(seg), .grid_o(grid), .shared_o(shr), .frame_end_o(fend), .sw_latched_o(swl)
  );

  always #5 clk = ~clk;

  // ---------------- reference model built from the requirements ----------
  int       ms, md;
  logic [7:0] mem [22];
  logic [3:0] esw;

  function automatic int ngrids();
    return int'(mode) + 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms <= 0; md <= 0; esw <= '0;
      for (int i = 0; i < 22; i++) mem[i] <= '0;
    end else begin
      if (wr_en && wr_addr < 5'd22) mem[wr_addr] <= wr_data;
      if (ms == SLOT - 1) begin
        ms <= 0;
        if (md >= ngrids() - 1) begin md <= 0; esw <= sw; end
        else md <= md + 1;
      end else ms <= ms + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string scen);
    logic [15:0] w;
    logic [10:0] e_seg;
    logic [5:0]  e_grid;
    logic [4:0]  e_shr;
    bit son, gon;
    w   = (md < 11) ? {mem[2*md+1], mem[2*md]} : 16'h0;
    son = disp_en && (ms >= DEAD);
    gon = son && (ms < (int'(dim) + 1) * (SLOT / 8));
    e_seg  = son ? w[10:0] : '0;
    e_grid = '0;
    if (gon && md < 6) e_grid[md] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      if (ngrids() >= 11 - k) e_shr[k] = gon && (md == 10 - k);
      else                    e_shr[k] = son && w[11 + k];
    end
    check(seg == e_seg, {scen, " R1/R6 seg"}, seg, e_seg);
    check(grid == e_grid, {scen, " R4/R5 grid"}, grid, e_grid);
    check(shr == e_shr, {scen, " R2/R7 shared"}, shr, e_shr);
    check(fend == ((ms == SLOT - 1) && (md >= ngrids() - 1)), {scen, " R3 frame_end"}, fend,
          (ms == SLOT - 1) && (md >= ngrids() - 1));
    check(swl == esw, {scen, " R9 sw latch"}, swl, esw);
  endtask

  task automatic run_cycles(input int n, input string scen);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      compare_all(scen);
    end
  endtask

  task automatic wr_byte(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_model(input int dig, input int cyc);
    do begin @(negedge clk); #1; end while (!(md == dig && ms == cyc));
  endtask

  // ---------------- scenarios -----------------------------------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(seg == '0 && grid == '0 && shr == '0, "R11 outputs dark in reset", {seg, grid, shr}, 0);
    check(swl == '0 && !fend, "R11 sw latch cleared", swl, 0);
    rst_n = 1'b1;
    disp_en = 1'b1;
    run_cycles(2 * SLOT, "R11 after reset");
  endtask

  task automatic t_mode11();
    mode = 3'd7; dim = 3'd7;
    for (int a = 0; a < 22; a++) wr_byte(5'(a), 8'(a * 37 + 11));
    run_cycles(11 * SLOT + 8, "R1 mode7");
  endtask

  task automatic t_mode16();
    mode = 3'd0;
    for (int a = 0; a < 8; a++) wr_byte(5'(a), 8'hF0 ^ 8'(a * 29));
    run_cycles(2 * 4 * SLOT, "R2 mode0");
  endtask

  task automatic t_mode_mid();
    mode = 3'd3; dim = 3'd2;
    for (int a = 0; a < 22; a++) wr_byte(5'(a), 8'hFF);
    run_cycles(2 * 7 * SLOT, "R7 mode3");
  endtask

  task automatic t_dim();
    int lit;
    for (int d = 0; d < 8; d += 7) begin
      dim = 3'(d);
      wait_model(0, 0);
      lit = 0;
      for (int i = 0; i < SLOT; i++) begin
        if (grid[0]) lit++;
        @(negedge clk); #1;
      end
      check(lit == (d + 1) * (SLOT / 8) - DEAD, "R5 grid on-time", lit, (d + 1) * (SLOT / 8) - DEAD);
      run_cycles(7 * SLOT, "R5 dim");
    end
  endtask

  task automatic t_disable();
    disp_en = 1'b0;
    for (int i = 0; i < 7 * SLOT; i++) begin
      @(negedge clk); #1;
      check(seg == '0 && grid == '0 && shr == '0, "R8 disabled dark", {seg, grid, shr}, 0);
    end
    run_cycles(7 * SLOT, "R8 scan continues");
    disp_en = 1'b1;
    run_cycles(7 * SLOT, "R8 re-enabled");
  endtask

  task automatic t_switch();
    sw = 4'hA;
    wait_model(0, 1);
    sw = 4'h5;
    wait_model(3, 4);
    check(swl == 4'hA, "R9 hold mid-frame", swl, 4'hA);
    run_cycles(2 * 7 * SLOT, "R9 switch");
    check(swl == 4'h5, "R9 captured at frame end", swl, 4'h5);
  endtask

  task automatic t_live_write();
    wait_model(0, DEAD + 1);
    wr_en = 1'b1; wr_addr = 5'd0; wr_data = 8'h5A;
    @(negedge clk); #1;
    wr_en = 1'b0;
    check(seg[7:0] == 8'h5A, "R10 write shows in current slot", seg[7:0], 8'h5A);
    run_cycles(7 * SLOT, "R10 live write");
  endtask

  task automatic t_bad_addr();
    for (int a = 22; a < 32; a++) wr_byte(5'(a), 8'h00);
    run_cycles(7 * SLOT, "R1 out-of-range write");
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_mode11();
    t_mode16();
    t_mode_mid();
    t_dim();
    t_disable();
    t_switch();
    t_live_write();
    t_bad_addr();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule